// File: doc/BRIEF.md
# SD host status, configuration and interrupt register block

This block keeps three software-visible registers of an SD card host controller: the host status word, the host configuration word and a debug word. The command and data engines report events by pulsing bits of a set vector, and software acknowledges them by writing ones to the status word. A single interrupt line is derived from the three interrupt-class status bits.

The debug word holds a 4-bit transfer state field and a live copy of the FIFO fill level. When software writes the power-down code 0xF into the state field, the block stores 0 there instead. When the data path signals a finished transfer, the block forces the field to the data-mode code 1.

Register access uses a plain synchronous bus. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read request. Word addresses: 0 status, 1 configuration, 2 debug. All other addresses read as zero.

Top module: `sdh_stat_irq`

## Requirements
- R1: After reset, status reads 0, configuration reads 0, debug reads 0x0000C60F and irq is low.
- R2: A pulse on status_set bit 7, 6, 5, 4, 3 or 0 sets the same status bit on the next edge. Status bits 2 and 1, and bits above 10, always read 0.
- R3: status_set bit 10 takes effect only while configuration bit 10 is 1. Bit 9 takes effect only while configuration bit 8 is 1. Bit 8 takes effect only while configuration bit 4 is 1.
- R4: A write to the status word clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a set pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: irq is high exactly when at least one of status bits 10, 9 or 8 is set, and it follows every status update.
- R7: The configuration word keeps write bits 10, 8, 5, 4, 3, 2, 1 and 0. All other bits read 0.
- R8: A debug write stores the written value. If bits 3:0 of the written value are 0xF, those bits are stored as 0.
- R9: A pulse on xfer_done sets debug bits 3:0 to 1 on the next edge, even if a debug write happens in the same cycle.
- R10: Debug bits 8:4 show the fifo_level input sampled at the previous clock edge, whatever software writes there.
- R11: reg_rdata shows the addressed register one cycle after reg_rd. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Word address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after reg_rd |
| status_set | input | 11 | Per-bit set pulses from the engines |
| xfer_done | input | 1 | Transfer-complete pulse from the data path |
| fifo_level | input | 5 | Current FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions: a set pulse and a write-one-to-clear landing on the same bit in the same cycle, and a power-down debug write coinciding with a transfer-complete pulse. The stimulus task drives the bus access, the set vector and xfer_done together in one cycle, so these collisions are applied on purpose. The behavioural model resolves each one from the requirements. The interrupt gating by the enable bits is exercised with each enable both off and on, and irq is compared on every clock.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int unsigned STAT_W = 11;
    localparam int unsigned CFG_W  = 11;
    localparam int unsigned FSM_W  = 4;
    localparam int unsigned LVL_W  = 5;
    localparam int unsigned LVL_LSB = 4;

    localparam int unsigned BIT_BUSY  = 10;
    localparam int unsigned BIT_BLOCK = 9;
    localparam int unsigned BIT_DATA  = 8;

    localparam int unsigned EN_BUSY  = 10;
    localparam int unsigned EN_BLOCK = 8;
    localparam int unsigned EN_DATA  = 4;

    localparam logic [STAT_W-1:0] STAT_IMPL = 11'h7F9;
    localparam logic [STAT_W-1:0] IRQ_MASK  = 11'h700;
    localparam logic [CFG_W-1:0]  CFG_IMPL  = 11'h53F;

    localparam logic [31:0]      DBG_RESET  = 32'h0000_C60F;
    localparam logic [FSM_W-1:0] FSM_IDENT  = 4'h0;
    localparam logic [FSM_W-1:0] FSM_DATA   = 4'h1;
    localparam logic [FSM_W-1:0] FSM_PWRDN  = 4'hF;

    localparam int unsigned ADR_STAT = 0;
    localparam int unsigned ADR_CFG  = 1;
    localparam int unsigned ADR_DBG  = 2;
endpackage

// File: rtl/sdh_status_reg.sv
module sdh_status_reg
    import sdh_pkg::*;
#(
    parameter int unsigned W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_raw,
    input  logic         en_busy,
    input  logic         en_block,
    input  logic         en_data,
    output logic [W-1:0] stat_o,
    output logic         irq_o
);
    localparam logic [W-1:0] IMPL = W'(STAT_IMPL);
    localparam logic [W-1:0] IMSK = W'(IRQ_MASK);

    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] set_g;
    logic [W-1:0] nxt;

    always_comb begin
        set_g = set_raw & IMPL;
        set_g[BIT_BUSY]  = set_g[BIT_BUSY]  & en_busy;
        set_g[BIT_BLOCK] = set_g[BIT_BLOCK] & en_block;
        set_g[BIT_DATA]  = set_g[BIT_DATA]  & en_data;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            assign nxt[i] = set_g[i] | (st_q.bits[i] & ~(clr_en & clr_bits[i]));
        end else begin : g_rsvd
            assign nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.bits;
    assign irq_o  = |(st_q.bits & IMSK);
endmodule

// File: rtl/sdh_cfg_reg.sv
module sdh_cfg_reg
    import sdh_pkg::*;
#(
    parameter int unsigned W  = CFG_W,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  cfg_o
);
    localparam logic [W-1:0] IMPL = W'(CFG_IMPL);

    typedef struct packed {
        logic [W-1:0] val;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d.val = wdata[W-1:0] & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q.val;
endmodule

// File: rtl/sdh_dbg_reg.sv
module sdh_dbg_reg
    import sdh_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic             done,
    input  logic [LVL_W-1:0] lvl,
    output logic [DW-1:0]    dbg_o
);
    typedef struct packed {
        logic [DW-1:0] val;
    } dbg_t;

    dbg_t dbg_d, dbg_q;

    always_comb begin
        dbg_d = dbg_q;
        if (wr_en) begin
            dbg_d.val = wdata;
            if (wdata[FSM_W-1:0] == FSM_PWRDN) dbg_d.val[FSM_W-1:0] = FSM_IDENT;
        end
        if (done) dbg_d.val[FSM_W-1:0] = FSM_DATA;
        dbg_d.val[LVL_LSB +: LVL_W] = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbg_q.val <= DW'(DBG_RESET);
        else        dbg_q     <= dbg_d;
    end

    assign dbg_o = dbg_q.val;
endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
    import sdh_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [STAT_W-1:0] status_set,
    input  logic              xfer_done,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              irq
);
    logic              sel_stat, sel_cfg, sel_dbg;
    logic [STAT_W-1:0] stat_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [DW-1:0]     dbg_q;

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    assign sel_stat = (reg_addr == AW'(ADR_STAT));
    assign sel_cfg  = (reg_addr == AW'(ADR_CFG));
    assign sel_dbg  = (reg_addr == AW'(ADR_DBG));

    sdh_status_reg #(.W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (reg_wr & sel_stat),
        .clr_bits (reg_wdata[STAT_W-1:0]),
        .set_raw  (status_set),
        .en_busy  (cfg_q[EN_BUSY]),
        .en_block (cfg_q[EN_BLOCK]),
        .en_data  (cfg_q[EN_DATA]),
        .stat_o   (stat_q),
        .irq_o    (irq)
    );

    sdh_cfg_reg #(.W(CFG_W), .DW(DW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr & sel_cfg),
        .wdata (reg_wdata),
        .cfg_o (cfg_q)
    );

    sdh_dbg_reg #(.DW(DW)) u_dbg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr & sel_dbg),
        .wdata (reg_wdata),
        .done  (xfer_done),
        .lvl   (fifo_level),
        .dbg_o (dbg_q)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            rd_d.data = '0;
            if (sel_stat) rd_d.data = DW'(stat_q);
            if (sel_cfg)  rd_d.data = DW'(cfg_q);
            if (sel_dbg)  rd_d.data = dbg_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.data;
endmodule

// File: rtl/sdh_stat_irq_chk.sv
module sdh_stat_irq_chk
    import sdh_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic [STAT_W-1:0] status_set,
    input logic              xfer_done,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              irq,
    input logic [STAT_W-1:0] stat_q,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [DW-1:0]     dbg_q
);
    logic unmapped;
    assign unmapped = (reg_addr != AW'(ADR_STAT)) && (reg_addr != AW'(ADR_CFG)) &&
                      (reg_addr != AW'(ADR_DBG));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|status_set[BIT_BUSY:BIT_DATA]));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(ADR_STAT)) |=>
        ((stat_q & $past(reg_wdata[STAT_W-1:0] & ~status_set)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_set[0] |=> stat_q[0]);

    // R3
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[EN_BUSY] && !stat_q[BIT_BUSY]) |=> !stat_q[BIT_BUSY]);

    // R8
    pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(ADR_DBG) && reg_wdata[FSM_W-1:0] == FSM_PWRDN && !xfer_done)
        |=> (dbg_q[FSM_W-1:0] == FSM_IDENT));

    // R9
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (dbg_q[FSM_W-1:0] == FSM_DATA));

    // R10
    lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dbg_q[LVL_LSB +: LVL_W] == $past(fifo_level)));

    // R11
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && unmapped) |=> (reg_rdata == '0));
endmodule

bind sdh_stat_irq sdh_stat_irq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .status_set (status_set),
    .xfer_done  (xfer_done),
    .fifo_level (fifo_level),
    .irq        (irq),
    .stat_q     (stat_q),
    .cfg_q      (cfg_q),
    .dbg_q      (dbg_q)
);

// File: tb/test_sdh_stat_irq.sv
module test_sdh_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] status_set = '0;
    logic        xfer_done = 1'b0;
    logic [4:0]  fifo_level = '0;
    logic        irq;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    logic [31:0] m_stat, m_cfg, m_dbg, exp_rd;
    bit          rd_valid;

    always #4 clk = ~clk;

    sdh_stat_irq i_sdh_stat_irq (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .status_set(status_set), .xfer_done(xfer_done),
        .fifo_level(fifo_level), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0:    return m_stat;
            4'd1:    return m_cfg;
            4'd2:    return m_dbg;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] set_g, clr, nd;
        if (!rst_n) begin
            m_stat = 0; m_cfg = 0; m_dbg = 32'h0000C60F; rd_valid = 0;
            return;
        end
        rd_valid = reg_rd;
        if (reg_rd) exp_rd = model_read(reg_addr);
        set_g = {21'h0, status_set} & 32'h7F9;
        if (!m_cfg[10]) set_g[10] = 0;
        if (!m_cfg[8])  set_g[9]  = 0;
        if (!m_cfg[4])  set_g[8]  = 0;
        clr = (reg_wr && reg_addr == 4'd0) ? reg_wdata : 32'h0;
        m_stat = ((m_stat & ~clr) | set_g) & 32'h7F9;
        nd = m_dbg;
        if (reg_wr && reg_addr == 4'd2) begin
            nd = reg_wdata;
            if (nd[3:0] == 4'hF) nd[3:0] = 4'h0;
        end
        if (xfer_done) nd[3:0] = 4'h1;
        nd[8:4] = fifo_level;
        m_dbg = nd;
        if (reg_wr && reg_addr == 4'd1) m_cfg = reg_wdata & 32'h53F;
    endtask

    task automatic compare();
        logic exp_irq;
        exp_irq = |m_stat[10:8];
        n_vec++;
        if (irq !== exp_irq) begin
            n_bad++;
            $display("FAIL R6 irq actual=%0b expected=%0b", irq, exp_irq);
        end
        if (rd_valid) begin
            n_vec++;
            if (reg_rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s rdata actual=%08h expected=%08h", cur_req, reg_rdata, exp_rd);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic op(input logic [3:0] a, input logic wr, input logic rd,
                      input logic [31:0] wd, input logic [10:0] st, input logic dn);
        reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        status_set = st; xfer_done = dn;
        tick();
        reg_wr = 0; reg_rd = 0; status_set = '0; xfer_done = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        op(a, 0, 1, 32'h0, '0, 0);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_step();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset values
        cur_req = "R1";
        rd(4'd0); rd(4'd1); rd(4'd2);
        // R2: plain status bits, reserved bits
        cur_req = "R2";
        op(4'd0, 0, 0, 0, 11'h0FF, 0);
        rd(4'd0);
        // R3: interrupt-class pulses ignored without enables
        cur_req = "R3";
        op(4'd0, 0, 0, 0, 11'h700, 0);
        rd(4'd0);
        // R7: configuration implemented bits
        cur_req = "R7";
        op(4'd1, 1, 0, 32'hFFFF_FFFF, '0, 0);
        rd(4'd1);
        // R3 / R6: each enabled pulse raises irq
        cur_req = "R3";
        op(4'd0, 0, 0, 0, 11'h200, 0);
        rd(4'd0);
        // R4: W1C clears only the written ones
        cur_req = "R4";
        op(4'd0, 1, 0, 32'h0000_0241, '0, 0);
        rd(4'd0);
        op(4'd0, 0, 0, 0, 11'h500, 0);
        op(4'd0, 1, 0, 32'h0000_0100, '0, 0);
        rd(4'd0);
        op(4'd0, 1, 0, 32'hFFFF_FFFF, '0, 0);
        rd(4'd0);
        // R5: set and clear in the same cycle
        cur_req = "R5";
        op(4'd0, 1, 0, 32'h0000_0FFF, 11'h481, 0);
        rd(4'd0);
        // R3: only the data enable set
        cur_req = "R3";
        op(4'd1, 1, 0, 32'h0000_0010, '0, 0);
        op(4'd0, 1, 0, 32'h0000_07FF, 11'h700, 0);
        rd(4'd0);
        // R8 / R10: debug write with power-down code
        cur_req = "R8";
        fifo_level = 5'd9;
        op(4'd2, 1, 0, 32'h1234_567F, '0, 0);
        rd(4'd2);
        op(4'd2, 1, 0, 32'hA5A5_A5A6, '0, 0);
        rd(4'd2);
        // R9: transfer done beats a write in the same cycle
        cur_req = "R9";
        op(4'd2, 1, 0, 32'h0000_000F, '0, 1);
        rd(4'd2);
        op(4'd0, 0, 0, 0, '0, 1);
        rd(4'd2);
        // R10: level tracking
        cur_req = "R10";
        for (int k = 0; k < 32; k += 7) begin
            fifo_level = 5'(k);
            tick();
            rd(4'd2);
        end
        // R11: unmapped addresses
        cur_req = "R11";
        op(4'd7, 1, 0, 32'hFFFF_FFFF, '0, 0);
        op(4'd15, 1, 1, 32'hFFFF_FFFF, '0, 0);
        tick();
        rd(4'd3);
        rd(4'd0); rd(4'd1); rd(4'd2);
        repeat (4) tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule